// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This block drives the start-up of a serial link through a link controller's register window. It acts as master on a simple 32-bit request/acknowledge register bus. It pins the controller's speed-cap field to the lowest generation, enables the link training state machine and polls a debug register until the link reports up. If the configured maximum generation is 2, it then raises the cap. In every successful case it asks for a directed speed change, waits for the change bit to clear by itself, confirms the link is up again and reports the negotiated speed.

Any poll that runs out of retries starts a recovery phase. The two receive override controls for the PHY (data enable and PLL enable) are asserted together for a fixed number of microsecond ticks and then released. The run then ends with the fail flag set. One start pulse runs one full sequence. Done and fail then stay as they are until the next accepted start.

Top module: `link_speed_seq`

## Requirements
- R1: After reset, `bus_req`, `ltssm_en`, `done`, `fail`, `phy_rec_req` and `rx_ovrd` are all low and `link_speed` is 0.
- R2: After an accepted start, the block first reads offset 0x07C. It then writes that value back with bits 3:0 replaced by 1 and all other bits kept. `ltssm_en` is low during that write, rises only after it completes, and is high for every read of the debug register.
- R3: The link counts as up when a read of offset 0x72C has bit 4 set and bit 29 clear. Bit 29 set means training is still in progress, and that read counts as not up. Successive debug reads are at least LINK_GAP_US ticks apart, and after LINK_POLLS reads that are not up the run fails.
- R4: `max_gen` is sampled at start. Only when it equals 2 does the block, after the first link-up, read 0x07C and write it back with bits 3:0 set to 2. For any other value no second write to 0x07C occurs.
- R5: The directed speed change is a read of offset 0x80C followed by a write of the same value with bit 17 set.
- R6: After that write, 0x80C is polled until bit 17 reads 0. Polls are at least SPD_GAP_US ticks apart, and SPD_POLLS reads that still show bit 17 set make the run fail.
- R7: Once bit 17 clears, the debug register is polled again under the same rules as R3, and success is declared only after that second link-up.
- R8: On success, offset 0x080 is read, `link_speed` takes bits 19:16 of that read, and `done` rises.
- R9: On any failure, `phy_rec_req` pulses for one cycle and `rx_ovrd` is 2'b11 for exactly RECOVER_US ticks. `rx_ovrd` is then cleared and `fail` rises. There is no bus traffic during recovery.
- R10: A start pulse while a sequence is running is ignored. `done` and `fail` are never high together, both clear on the next accepted start, and otherwise hold their value.
- R11: A bus request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stable until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| max_gen | input | 2 | Highest generation allowed; 2 enables the speed raise |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte offset of the register |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access complete; read data valid in the same cycle |
| bus_rdata | input | DW | Read data |
| ltssm_en | output | 1 | Enables link training in the controller |
| done | output | 1 | Sequence finished with the link up |
| fail | output | 1 | Sequence finished after a timeout and recovery |
| link_speed | output | 4 | Negotiated generation read at the end of a successful run |
| phy_rec_req | output | 1 | One-cycle pulse at the start of recovery |
| rx_ovrd | output | 2 | Receive override: bit 1 PLL enable, bit 0 data enable |

## Verification
Each register access appears on the bus one cycle after the sequencer enters the step that needs it. The decision on a read's data is taken one cycle after the acknowledge. So the bench model acknowledges and records on falling edges, and compares each write with the scoreboard head in the same cycle that the acknowledge is given. Poll spacing and recovery length are measured in microsecond ticks, counted on the falling edge before the rising edge that consumes them, so the recovery count must equal RECOVER_US exactly. Final flags, speed and access counts are read only after `done` or `fail` has risen, and again three cycles later to confirm they hold.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CAP_RD,
      S_CAP_WR,
      S_LU_RD,
      S_LU_GAP,
      S_CAP2_RD,
      S_CAP2_WR,
      S_SC_RD,
      S_SC_WR,
      S_SC_POLL,
      S_SC_GAP,
      S_STS_RD,
      S_REC
   } seq_state_e;

   // register offsets inside the controller window
   localparam int OFF_CAP = 'h07C;
   localparam int OFF_STS = 'h080;
   localparam int OFF_DBG = 'h72C;
   localparam int OFF_SPD = 'h80C;

   // field positions decoded by the sequencer
   localparam int CAP_W         = 4;
   localparam int DBG_UP_BIT    = 4;
   localparam int DBG_TRAIN_BIT = 29;
   localparam int SPD_CHG_BIT   = 17;
   localparam int STS_SPD_LSB   = 16;

endpackage

// File: rtl/lss_bus_master.sv
module lss_bus_master #(
   parameter int AW        = 12,
   parameter int DW        = 32,
   parameter bit REG_RDATA = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_we,
   input  logic [AW-1:0] go_addr,
   input  logic [DW-1:0] go_wdata,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata,
   output logic          xfer_done,
   output logic [DW-1:0] xfer_rdata
);

   logic hit;
   assign hit = bus_req && bus_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else if (hit) begin
         bus_req <= 1'b0;
      end else if (go && !bus_req) begin
         bus_req   <= 1'b1;
         bus_we    <= go_we;
         bus_addr  <= go_addr;
         bus_wdata <= go_wdata;
      end
   end

   generate
      if (REG_RDATA) begin : g_reg
         logic          done_q;
         logic [DW-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               done_q  <= 1'b0;
               rdata_q <= '0;
            end else begin
               done_q <= hit;
               if (hit) rdata_q <= bus_rdata;
            end
         end
         assign xfer_done  = done_q;
         assign xfer_rdata = rdata_q;
      end else begin : g_thru
         assign xfer_done  = hit;
         assign xfer_rdata = bus_rdata;
      end
   endgenerate

   // R11: request and its payload hold until acknowledged
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

endmodule

// File: rtl/lss_us_timer.sv
module lss_us_timer #(
   parameter int TW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          us_tick,
   output logic          fire
);

   logic [TW-1:0] cnt_q;

   assign fire = us_tick && (cnt_q == TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load)                    cnt_q <= load_val;
      else if (us_tick && cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
   end

endmodule

// File: rtl/lss_poll_ctr.sv
module lss_poll_ctr #(
   parameter int PW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          bump,
   input  logic [PW-1:0] limit,
   output logic          at_last
);

   logic [PW-1:0] cnt_q;

   assign at_last = (cnt_q == limit - PW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (bump)  cnt_q <= cnt_q + PW'(1);
   end

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
   import lss_pkg::*;
#(
   parameter int AW                 = 12,
   parameter int DW                 = 32,
   parameter int LINK_POLLS         = 1000,
   parameter int LINK_GAP_US        = 1,
   parameter int SPD_POLLS          = 200,
   parameter int SPD_GAP_US         = 100,
   parameter int RECOVER_US         = 2000,
   parameter bit REQUIRE_TRAIN_DONE = 1,
   parameter bit REG_RDATA          = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    max_gen,
   input  logic          us_tick,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata,
   output logic          ltssm_en,
   output logic          done,
   output logic          fail,
   output logic [3:0]    link_speed,
   output logic          phy_rec_req,
   output logic [1:0]    rx_ovrd
);

   localparam int POLL_MAX = (LINK_POLLS > SPD_POLLS) ? LINK_POLLS : SPD_POLLS;
   localparam int PW       = $clog2(POLL_MAX + 1);
   localparam int GAP_MAX  = (LINK_GAP_US > SPD_GAP_US) ? LINK_GAP_US : SPD_GAP_US;
   localparam int TMR_MAX  = (GAP_MAX > RECOVER_US) ? GAP_MAX : RECOVER_US;
   localparam int TW       = $clog2(TMR_MAX + 1);

   // elaboration-time parameter checks
   if (DW < 32) begin : g_bad_dw
      $error("DW must be at least 32");
   end
   if (AW < 12) begin : g_bad_aw
      $error("AW must cover offset 0x80C");
   end
   if (LINK_POLLS < 1 || SPD_POLLS < 1) begin : g_bad_polls
      $error("poll limits must be at least 1");
   end
   if (LINK_GAP_US < 1 || SPD_GAP_US < 1 || RECOVER_US < 1) begin : g_bad_time
      $error("intervals must be at least one tick");
   end

   seq_state_e    state_q, state_d;
   logic          in_flight_q;
   logic [DW-1:0] rmw_q;
   logic          gen2_q, second_q;
   logic          ltssm_q, done_q, fail_q, rec_pulse_q;
   logic [3:0]    speed_q;

   logic          op_go, op_we, bus_step;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_wdata;
   logic          xfer_done;
   logic [DW-1:0] xfer_rdata;
   logic          dbg_up;

   logic          tmr_load, tmr_fire;
   logic [TW-1:0] tmr_val;
   logic          pc_clr, pc_bump, pc_last;
   logic [PW-1:0] pc_limit;

   // link-up decode variant
   generate
      if (REQUIRE_TRAIN_DONE) begin : g_up_strict
         assign dbg_up = xfer_rdata[DBG_UP_BIT] && !xfer_rdata[DBG_TRAIN_BIT];
      end else begin : g_up_loose
         assign dbg_up = xfer_rdata[DBG_UP_BIT];
      end
   endgenerate

   // bus step decode
   always_comb begin
      bus_step = 1'b1;
      op_we    = 1'b0;
      op_addr  = '0;
      op_wdata = '0;
      unique case (state_q)
         S_CAP_RD:  op_addr = AW'(OFF_CAP);
         S_CAP_WR:  begin
            op_addr  = AW'(OFF_CAP);
            op_we    = 1'b1;
            op_wdata = {rmw_q[DW-1:CAP_W], CAP_W'(1)};
         end
         S_LU_RD:   op_addr = AW'(OFF_DBG);
         S_CAP2_RD: op_addr = AW'(OFF_CAP);
         S_CAP2_WR: begin
            op_addr  = AW'(OFF_CAP);
            op_we    = 1'b1;
            op_wdata = {rmw_q[DW-1:CAP_W], CAP_W'(2)};
         end
         S_SC_RD:   op_addr = AW'(OFF_SPD);
         S_SC_WR:   begin
            op_addr  = AW'(OFF_SPD);
            op_we    = 1'b1;
            op_wdata = rmw_q | (DW'(1) << SPD_CHG_BIT);
         end
         S_SC_POLL: op_addr = AW'(OFF_SPD);
         S_STS_RD:  op_addr = AW'(OFF_STS);
         default:   bus_step = 1'b0;
      endcase
   end

   assign op_go    = bus_step && !in_flight_q;
   assign pc_limit = (state_q == S_SC_POLL) ? PW'(SPD_POLLS) : PW'(LINK_POLLS);

   // next-state logic
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      pc_clr   = 1'b0;
      pc_bump  = 1'b0;
      unique case (state_q)
         S_IDLE:    if (start) state_d = S_CAP_RD;
         S_CAP_RD:  if (xfer_done) state_d = S_CAP_WR;
         S_CAP_WR:  if (xfer_done) begin
            state_d = S_LU_RD;
            pc_clr  = 1'b1;
         end
         S_LU_RD:   if (xfer_done) begin
            if (dbg_up) begin
               pc_clr  = 1'b1;
               state_d = second_q ? S_STS_RD : (gen2_q ? S_CAP2_RD : S_SC_RD);
            end else if (pc_last) begin
               state_d  = S_REC;
               tmr_load = 1'b1;
               tmr_val  = TW'(RECOVER_US);
            end else begin
               pc_bump  = 1'b1;
               state_d  = S_LU_GAP;
               tmr_load = 1'b1;
               tmr_val  = TW'(LINK_GAP_US);
            end
         end
         S_LU_GAP:  if (tmr_fire) state_d = S_LU_RD;
         S_CAP2_RD: if (xfer_done) state_d = S_CAP2_WR;
         S_CAP2_WR: if (xfer_done) state_d = S_SC_RD;
         S_SC_RD:   if (xfer_done) state_d = S_SC_WR;
         S_SC_WR:   if (xfer_done) begin
            state_d = S_SC_POLL;
            pc_clr  = 1'b1;
         end
         S_SC_POLL: if (xfer_done) begin
            if (!xfer_rdata[SPD_CHG_BIT]) begin
               pc_clr  = 1'b1;
               state_d = S_LU_RD;
            end else if (pc_last) begin
               state_d  = S_REC;
               tmr_load = 1'b1;
               tmr_val  = TW'(RECOVER_US);
            end else begin
               pc_bump  = 1'b1;
               state_d  = S_SC_GAP;
               tmr_load = 1'b1;
               tmr_val  = TW'(SPD_GAP_US);
            end
         end
         S_SC_GAP:  if (tmr_fire) state_d = S_SC_POLL;
         S_STS_RD:  if (xfer_done) state_d = S_IDLE;
         S_REC:     if (tmr_fire) state_d = S_IDLE;
         default:   state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         in_flight_q <= 1'b0;
         rmw_q       <= '0;
         gen2_q      <= 1'b0;
         second_q    <= 1'b0;
         ltssm_q     <= 1'b0;
         done_q      <= 1'b0;
         fail_q      <= 1'b0;
         rec_pulse_q <= 1'b0;
         speed_q     <= '0;
      end else begin
         state_q     <= state_d;
         rec_pulse_q <= (state_q != S_REC) && (state_d == S_REC);
         if (xfer_done)  in_flight_q <= 1'b0;
         else if (op_go) in_flight_q <= 1'b1;
         if (xfer_done)  rmw_q <= xfer_rdata;
         if (state_q == S_IDLE && start) begin
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            ltssm_q  <= 1'b0;
            second_q <= 1'b0;
            gen2_q   <= (max_gen == 2'd2);
         end
         if (state_q == S_CAP_WR && xfer_done) ltssm_q <= 1'b1;
         if (state_q == S_SC_POLL && xfer_done && !xfer_rdata[SPD_CHG_BIT]) second_q <= 1'b1;
         if (state_q == S_STS_RD && xfer_done) begin
            done_q  <= 1'b1;
            speed_q <= xfer_rdata[STS_SPD_LSB +: 4];
         end
         if (state_q == S_REC && tmr_fire) fail_q <= 1'b1;
      end
   end

   lss_bus_master #(.AW(AW), .DW(DW), .REG_RDATA(REG_RDATA)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (op_go),
      .go_we      (op_we),
      .go_addr    (op_addr),
      .go_wdata   (op_wdata),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata),
      .xfer_done  (xfer_done),
      .xfer_rdata (xfer_rdata)
   );

   lss_us_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .us_tick  (us_tick),
      .fire     (tmr_fire)
   );

   lss_poll_ctr #(.PW(PW)) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pc_clr),
      .bump    (pc_bump),
      .limit   (pc_limit),
      .at_last (pc_last)
   );

   assign ltssm_en    = ltssm_q;
   assign done        = done_q;
   assign fail        = fail_q;
   assign link_speed  = speed_q;
   assign phy_rec_req = rec_pulse_q;
   assign rx_ovrd     = {2{state_q == S_REC}};

   // R2: training is enabled right after the speed-cap write
   a_r2_ltssm_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ltssm_en) |-> bus_we && bus_addr == AW'(OFF_CAP));
   // R8: done follows the status read
   a_r8_done_after_sts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !bus_we && bus_addr == AW'(OFF_STS));
   // R9: recovery request is a single-cycle pulse
   a_r9_rec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rec_req |=> !phy_rec_req);
   // R9: no bus traffic while overrides are held
   a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovrd != 2'b00 |-> !bus_req);
   // R10: outcome flags are exclusive and sticky
   a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
   a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
   a_r10_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fail && !start |=> fail);

endmodule

// File: tb/link_speed_seq_tb.sv
module link_speed_seq_tb;

   localparam int CLK_PERIOD  = 10;
   localparam int AW          = 12;
   localparam int DW          = 32;
   localparam int LINK_POLLS  = 12;
   localparam int LINK_GAP_US = 2;
   localparam int SPD_POLLS   = 6;
   localparam int SPD_GAP_US  = 4;
   localparam int RECOVER_US  = 20;
   localparam int LAT         = 1;
   localparam int NEVER       = 100000;

   localparam logic [31:0] CAP_INIT = 32'h1234_567B;
   localparam logic [31:0] SPD_INIT = 32'h0001_00A5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    max_gen = 2'd1;
   logic          us_tick = 1'b0;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic          ltssm_en, done, fail, phy_rec_req;
   logic [3:0]    link_speed;
   logic [1:0]    rx_ovrd;

   link_speed_seq #(
      .AW(AW), .DW(DW), .LINK_POLLS(LINK_POLLS), .LINK_GAP_US(LINK_GAP_US),
      .SPD_POLLS(SPD_POLLS), .SPD_GAP_US(SPD_GAP_US), .RECOVER_US(RECOVER_US)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .max_gen(max_gen), .us_tick(us_tick),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .ltssm_en(ltssm_en), .done(done),
      .fail(fail), .link_speed(link_speed), .phy_rec_req(phy_rec_req), .rx_ovrd(rx_ovrd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // scoreboard of expected writes
   typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
   wr_t exp_q[$];

   task automatic push_wr(logic [AW-1:0] a, logic [DW-1:0] d);
      wr_t w;
      w.a = a;
      w.d = d;
      exp_q.push_back(w);
   endtask

   // register model state and measurements
   logic [31:0] cap_reg, spd_reg;
   logic [3:0]  sts_speed;
   bit          spd_written, lu2_fail;
   int          lu_delay, busy_cnt, spd_hold;
   int          dbg1, dbg2, spd_rd, spd_polls, cap_wr, bad_dbg;
   int          rec_ticks, rec_pulses, tick_cnt, last_dbg_tick, last_spd_tick;
   int          lat_cnt = 0;

   task automatic mon_write();
      wr_t w;
      if (bus_addr == AW'('h07C)) begin
         if (cap_wr == 0) chk(ltssm_en == 1'b0, "R2", "ltssm_en during cap write", ltssm_en, 0);
         cap_wr++;
      end
      if (exp_q.size() == 0) begin
         chk(1'b0, "R4", "unexpected write addr", bus_addr, 0);
      end else begin
         w = exp_q.pop_front();
         chk(bus_addr == w.a, "R5", "write address", bus_addr, w.a);
         chk(bus_wdata == w.d, "R2", "write data", bus_wdata, w.d);
      end
   endtask

   task automatic serve();
      logic [31:0] v;
      v = '0;
      case (bus_addr)
         AW'('h07C): if (bus_we) begin mon_write(); cap_reg = bus_wdata; end
                     else v = cap_reg;
         AW'('h72C): if (!bus_we) begin
            if (!ltssm_en) bad_dbg++;
            if (!spd_written) begin
               dbg1++;
               if (dbg1 > 1)
                  chk(tick_cnt - last_dbg_tick >= LINK_GAP_US, "R3", "debug poll spacing",
                      tick_cnt - last_dbg_tick, LINK_GAP_US);
               last_dbg_tick = tick_cnt;
               if (dbg1 <= lu_delay) v = 32'h0;
               else if (dbg1 <= lu_delay + busy_cnt) v = (32'h1 << 4) | (32'h1 << 29);
               else v = 32'h1 << 4;
            end else begin
               dbg2++;
               v = lu2_fail ? 32'h0 : (32'h1 << 4);
            end
         end
         AW'('h80C): if (bus_we) begin mon_write(); spd_reg = bus_wdata; spd_written = 1; end
            else begin
               spd_rd++;
               if (spd_written) begin
                  spd_polls++;
                  if (spd_polls > 1)
                     chk(tick_cnt - last_spd_tick >= SPD_GAP_US, "R6", "speed poll spacing",
                         tick_cnt - last_spd_tick, SPD_GAP_US);
                  last_spd_tick = tick_cnt;
                  if (spd_polls > spd_hold) spd_reg[17] = 1'b0;
               end
               v = spd_reg;
            end
         AW'('h080): v = {12'h0, sts_speed, 16'h0011};
         default: v = 32'hDEAD_BEEF;
      endcase
      bus_rdata = v;
   endtask

   // bus slave, register model and monitors (falling edge)
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0;
         us_tick = 1'b0;
         lat_cnt = 0;
      end else begin
         if (rx_ovrd == 2'b11 && us_tick) rec_ticks++;
         if (phy_rec_req) rec_pulses++;
         if (us_tick) tick_cnt++;
         if (bus_ack) bus_ack = 1'b0;
         else if (bus_req) begin
            if (lat_cnt < LAT) lat_cnt++;
            else begin
               lat_cnt = 0;
               bus_ack = 1'b1;
               serve();
            end
         end
         us_tick = ~us_tick;
      end
   end

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finish_up();
   end

   task automatic run_case(string name, int gen, int d1, int busy, int hold, bit l2f,
                           logic [3:0] spd, bit poke);
      int  need1, exp_dbg1, exp_spd_rd, exp_dbg2;
      bit  ok1, ok2, exp_done;
      int  i;
      cap_reg = CAP_INIT; spd_reg = SPD_INIT; sts_speed = spd;
      lu_delay = d1; busy_cnt = busy; spd_hold = hold; lu2_fail = l2f;
      spd_written = 0; dbg1 = 0; dbg2 = 0; spd_rd = 0; spd_polls = 0; cap_wr = 0;
      bad_dbg = 0; rec_ticks = 0; rec_pulses = 0;
      need1    = d1 + busy + 1;
      ok1      = need1 <= LINK_POLLS;
      ok2      = (hold + 1) <= SPD_POLLS;
      exp_dbg1 = ok1 ? need1 : LINK_POLLS;
      exp_spd_rd = ok1 ? 1 + (ok2 ? hold + 1 : SPD_POLLS) : 0;
      exp_dbg2 = (ok1 && ok2) ? (l2f ? LINK_POLLS : 1) : 0;
      exp_done = ok1 && ok2 && !l2f;
      push_wr(AW'('h07C), {CAP_INIT[31:4], 4'd1});
      if (ok1) begin
         if (gen == 2) push_wr(AW'('h07C), {CAP_INIT[31:4], 4'd2});
         push_wr(AW'('h80C), SPD_INIT | (32'h1 << 17));
      end
      $display("case %s", name);
      @(negedge clk);
      max_gen = 2'(gen);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && !fail, "R10", "flags cleared by start", {done, fail}, 0);
      if (poke) begin
         repeat (10) @(negedge clk);
         max_gen = 2'd1;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      i = 0;
      while (!(done || fail) && i < 20000) begin
         @(negedge clk);
         i++;
      end
      chk(done == exp_done, "R8", "done", done, exp_done);
      chk(fail == !exp_done, "R9", "fail", fail, !exp_done);
      chk(dbg1 == exp_dbg1, "R3", "first-phase debug reads", dbg1, exp_dbg1);
      chk(spd_rd == exp_spd_rd, "R6", "speed register reads", spd_rd, exp_spd_rd);
      chk(dbg2 == exp_dbg2, "R7", "second-phase debug reads", dbg2, exp_dbg2);
      chk(exp_q.size() == 0, "R4", "writes left in scoreboard", exp_q.size(), 0);
      chk(bad_dbg == 0, "R2", "debug reads with training off", bad_dbg, 0);
      chk(ltssm_en == 1'b1, "R2", "ltssm_en after run", ltssm_en, 1);
      chk(rec_ticks == (exp_done ? 0 : RECOVER_US), "R9", "override ticks", rec_ticks,
          exp_done ? 0 : RECOVER_US);
      chk(rec_pulses == (exp_done ? 0 : 1), "R9", "recovery pulses", rec_pulses, exp_done ? 0 : 1);
      chk(rx_ovrd == 2'b00, "R9", "overrides released", rx_ovrd, 0);
      if (exp_done) begin
         chk(link_speed == spd, "R8", "link_speed", link_speed, spd);
         chk(cap_reg[3:0] == ((gen == 2) ? 4'd2 : 4'd1), "R4", "final cap field", cap_reg[3:0],
             (gen == 2) ? 2 : 1);
      end
      repeat (3) @(negedge clk);
      chk(done == exp_done && fail == !exp_done, "R10", "flags held", {done, fail},
          {exp_done, !exp_done});
      while (exp_q.size() > 0) void'(exp_q.pop_front());
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_req && !ltssm_en && !done && !fail, "R1", "control outputs after reset",
          {bus_req, ltssm_en, done, fail}, 0);
      chk(!phy_rec_req && rx_ovrd == 2'b00 && link_speed == 4'd0, "R1", "recovery/speed after reset",
          {phy_rec_req, rx_ovrd, link_speed}, 0);
      run_case("gen1 link", 1, 2, 0, 2, 0, 4'd1, 0);
      run_case("gen2 with busy start", 2, 3, 0, 0, 0, 4'd2, 1);
      run_case("gen2 training bit", 2, 0, 3, 1, 0, 4'd2, 0);
      run_case("link timeout", 2, NEVER, 0, 0, 0, 4'd1, 0);
      run_case("speed change timeout", 2, 1, 0, NEVER, 0, 4'd2, 0);
      run_case("second link-up lost", 1, 0, 0, 1, 1, 4'd1, 0);
      run_case("max_gen 3 stays gen1", 3, 0, 1, 0, 0, 4'd1, 0);
      finish_up();
   end

endmodule